// File: doc/BRIEF.md
# Multi-Size Translation Buffer

This block is a fully associative address translation cache that maps 32-bit virtual addresses to 32-bit physical addresses. Each of its slots holds one translation. A per-slot region code says whether the translation covers 4 KB, 64 KB or 1 MB, so each slot compares a different number of upper address bits. A lookup request is answered one cycle later with a hit flag, the physical address and the slot's permission bits.

New translations come in through a refill port. The refill overwrites the slot chosen by a round-robin pointer, which moves on by one slot only when a refill happens. A maintenance port can invalidate every slot at once. It can also invalidate only the slots that cover a given virtual address. The parameter `FLUSH_ONE_EN` removes that second function, so the same RTL can serve the instruction side, where only flush-all exists.

Top module: `tlb_multisize`

## Requirements
- R1: After reset every slot is invalid, the replacement pointer is at slot 0, and any lookup misses.
- R2: A lookup request sampled at a clock edge drives `lk_rsp_o` high after that edge, for exactly one cycle. `lk_hit_o` is never high while `lk_rsp_o` is low.
- R3: Region codes are as follows. Code 0 is 4 KB and compares VA[31:12]. Code 1 is 64 KB and compares VA[31:16]. Code 2 is 1 MB and compares VA[31:20]. Code 3 behaves like code 0. Address bits below the region size are ignored, both in the stored tag and in the lookup address.
- R4: On a hit, the physical address takes the slot's frame bits above the region size and the lookup address bits below it. `lk_perm_o` returns the stored permission bits. On a miss, `lk_pa_o` and `lk_perm_o` are zero.
- R5: When several valid slots match, the lowest-numbered slot supplies the result.
- R6: A refill writes the slot at the pointer and makes it valid. The pointer advances by one only on a refill and wraps from slot 31 to slot 0. So the 33rd refill after reset replaces the first one.
- R7: A flush-all request invalidates every slot in one cycle.
- R8: With `FLUSH_ONE_EN`=1, a flush-one request invalidates, in one cycle, every valid slot whose tag matches `fl_va_i` under that slot's own region size. All other slots keep their state.
- R9: With `FLUSH_ONE_EN`=0, `fl_one_i` has no effect on any slot.
- R10: A lookup issued in the same cycle as a flush or a refill is answered from the contents as they were before that cycle's update.
- R11: When a refill and a flush happen in the same cycle, the refilled slot ends up valid with the new contents. The flush acts only on the other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_rsp_o | output | 1 | Lookup response valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | 32 | Translated physical address |
| lk_perm_o | output | PERM_W | Permission bits of the hitting slot |
| rf_we_i | input | 1 | Refill write strobe |
| rf_va_i | input | 32 | Refill virtual address |
| rf_pa_i | input | 32 | Refill physical address |
| rf_rgn_i | input | 2 | Refill region code |
| rf_perm_i | input | PERM_W | Refill permission bits |
| fl_all_i | input | 1 | Invalidate all slots |
| fl_one_i | input | 1 | Invalidate slots covering fl_va_i |
| fl_va_i | input | 32 | Address for the single flush |

## Verification
A lookup result is registered once. Hit, address and permissions are therefore due at the first rising edge after the request. The bench drives each request just after a falling edge and reads the outputs at the next falling edge, half a period after they update. Refills and flushes take effect at the edge where they are sampled, so a lookup issued in the following cycle must see the new contents. A lookup issued in the same cycle is checked against the bench model's state from before the update. The bench sweeps lookups across the region boundaries of each size, offset by one on either side. It also fills all 32 slots and checks that the pointer wraps back to the first.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int ADDR_W = 32;
  localparam int PG_SHIFT = 12;
  localparam int VPN_W = ADDR_W - PG_SHIFT;

  typedef enum logic [1:0] {
    RGN_4K  = 2'd0,
    RGN_64K = 2'd1,
    RGN_1M  = 2'd2,
    RGN_RSV = 2'd3
  } rgn_e;

  // bits of the page number that take part in the tag compare
  function automatic logic [VPN_W-1:0] keep_mask(input rgn_e r);
    case (r)
      RGN_64K: keep_mask = {{(VPN_W-4){1'b1}}, 4'h0};
      RGN_1M:  keep_mask = {{(VPN_W-8){1'b1}}, 8'h00};
      default: keep_mask = {VPN_W{1'b1}};
    endcase
  endfunction

  function automatic logic vpn_match(input logic [VPN_W-1:0] a,
                                     input logic [VPN_W-1:0] b,
                                     input rgn_e r);
    vpn_match = ((a ^ b) & keep_mask(r)) == '0;
  endfunction

  function automatic logic [ADDR_W-1:0] join_pa(input logic [VPN_W-1:0] pfn,
                                                input logic [ADDR_W-1:0] va,
                                                input rgn_e r);
    logic [VPN_W-1:0] k;
    k = keep_mask(r);
    join_pa = {(pfn & k) | (va[ADDR_W-1:PG_SHIFT] & ~k), va[PG_SHIFT-1:0]};
  endfunction
endpackage

// File: rtl/tlbm_slot.sv
module tlbm_slot
  import tlbm_pkg::*;
#(
  parameter int PERM_W = 4,
  parameter bit FLUSH_ONE_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [VPN_W-1:0]  wr_pfn_i,
  input  logic [1:0]        wr_rgn_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic              fl_all_i,
  input  logic              fl_one_i,
  input  logic [VPN_W-1:0]  fl_vpn_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              valid_o,
  output logic              match_o,
  output logic [VPN_W-1:0]  pfn_o,
  output logic [1:0]        rgn_o,
  output logic [PERM_W-1:0] perm_o
);
  logic              valid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [VPN_W-1:0]  pfn_q;
  logic [1:0]        rgn_q;
  logic [PERM_W-1:0] perm_q;
  logic              fl_hit;
  logic              drop;

  generate
    if (FLUSH_ONE_EN) begin : g_fl_one
      assign fl_hit = fl_one_i & valid_q & vpn_match(fl_vpn_i, vpn_q, rgn_e'(rgn_q));
    end else begin : g_no_fl_one
      assign fl_hit = 1'b0;
    end
  endgenerate

  assign drop = fl_all_i | fl_hit;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) valid_q <= 1'b0;
    else if (wr_i) valid_q <= 1'b1;
    else if (drop) valid_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      vpn_q  <= wr_vpn_i;
      pfn_q  <= wr_pfn_i;
      rgn_q  <= wr_rgn_i;
      perm_q <= wr_perm_i;
    end
  end

  assign valid_o = valid_q;
  assign match_o = valid_q & vpn_match(lk_vpn_i, vpn_q, rgn_e'(rgn_q));
  assign pfn_o   = pfn_q;
  assign rgn_o   = rgn_q;
  assign perm_o  = perm_q;

  // R7
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_all_i && !wr_i |=> !valid_o);
  // R8
  flush_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_hit && !wr_i |=> !valid_o);
  // R11
  refill_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_o);
endmodule

// File: rtl/tlbm_rr.sv
module tlbm_rr #(
  parameter int ENTRIES = 32,
  localparam int PTR_W = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  output logic [PTR_W-1:0]   ptr_o,
  output logic [ENTRIES-1:0] sel_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);
  logic [PTR_W-1:0] ptr_q;
  logic             at_last;

  assign at_last = ptr_q == LAST;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i) ptr_q <= at_last ? '0 : ptr_q + 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_sel
      assign sel_o[g] = ptr_q == PTR_W'(g);
    end
  endgenerate

  assign ptr_o = ptr_q;

  // R6
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && at_last |=> ptr_o == '0);
  // R6
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/tlbm_pick.sv
module tlbm_pick
  import tlbm_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PERM_W = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             match_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  pfn_i,
  input  logic [ENTRIES-1:0][1:0]        rgn_i,
  input  logic [ENTRIES-1:0][PERM_W-1:0] perm_i,
  output logic                           any_o,
  output logic [IDX_W-1:0]               idx_o,
  output logic [VPN_W-1:0]               pfn_o,
  output logic [1:0]                     rgn_o,
  output logic [PERM_W-1:0]              perm_o
);
  // lowest index wins: scan from the top so the lowest match is written last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    pfn_o  = pfn_i[idx_o];
    rgn_o  = rgn_i[idx_o];
    perm_o = perm_i[idx_o];
  end
endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize
  import tlbm_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PERM_W = 4,
  parameter bit FLUSH_ONE_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [31:0]       lk_va_i,
  output logic              lk_rsp_o,
  output logic              lk_hit_o,
  output logic [31:0]       lk_pa_o,
  output logic [PERM_W-1:0] lk_perm_o,
  input  logic              rf_we_i,
  input  logic [31:0]       rf_va_i,
  input  logic [31:0]       rf_pa_i,
  input  logic [1:0]        rf_rgn_i,
  input  logic [PERM_W-1:0] rf_perm_i,
  input  logic              fl_all_i,
  input  logic              fl_one_i,
  input  logic [31:0]       fl_va_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_v;
  logic [ENTRIES-1:0]             match_v;
  logic [ENTRIES-1:0]             rr_sel;
  logic [ENTRIES-1:0][VPN_W-1:0]  pfn_a;
  logic [ENTRIES-1:0][1:0]        rgn_a;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_a;
  logic [IDX_W-1:0]               rr_ptr;
  logic                           pick_any;
  logic [IDX_W-1:0]               pick_idx;
  logic [VPN_W-1:0]               pick_pfn;
  logic [1:0]                     pick_rgn;
  logic [PERM_W-1:0]              pick_perm;
  logic                           lk_take_hit;

  tlbm_rr #(.ENTRIES(ENTRIES)) rr_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (rf_we_i),
    .ptr_o (rr_ptr),
    .sel_o (rr_sel)
  );

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_slot
      tlbm_slot #(.PERM_W(PERM_W), .FLUSH_ONE_EN(FLUSH_ONE_EN)) slot_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (rf_we_i & rr_sel[g]),
        .wr_vpn_i (rf_va_i[31:PG_SHIFT]),
        .wr_pfn_i (rf_pa_i[31:PG_SHIFT]),
        .wr_rgn_i (rf_rgn_i),
        .wr_perm_i(rf_perm_i),
        .fl_all_i (fl_all_i),
        .fl_one_i (fl_one_i),
        .fl_vpn_i (fl_va_i[31:PG_SHIFT]),
        .lk_vpn_i (lk_va_i[31:PG_SHIFT]),
        .valid_o  (valid_v[g]),
        .match_o  (match_v[g]),
        .pfn_o    (pfn_a[g]),
        .rgn_o    (rgn_a[g]),
        .perm_o   (perm_a[g])
      );
    end
  endgenerate

  tlbm_pick #(.ENTRIES(ENTRIES), .PERM_W(PERM_W)) pick_i (
    .match_i(match_v),
    .pfn_i  (pfn_a),
    .rgn_i  (rgn_a),
    .perm_i (perm_a),
    .any_o  (pick_any),
    .idx_o  (pick_idx),
    .pfn_o  (pick_pfn),
    .rgn_o  (pick_rgn),
    .perm_o (pick_perm)
  );

  assign lk_take_hit = lk_req_i & pick_any;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lk_rsp_o  <= 1'b0;
      lk_hit_o  <= 1'b0;
      lk_pa_o   <= '0;
      lk_perm_o <= '0;
    end else begin
      lk_rsp_o  <= lk_req_i;
      lk_hit_o  <= lk_take_hit;
      lk_pa_o   <= lk_take_hit ? join_pa(pick_pfn, lk_va_i, rgn_e'(pick_rgn)) : '0;
      lk_perm_o <= lk_take_hit ? pick_perm : '0;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_rsp_o);
  // R2
  hit_needs_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_rsp_o |-> !lk_hit_o);
  // R5
  pick_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_any |-> match_v[pick_idx]);
  // R6
  refill_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_i |=> valid_v[$past(rr_ptr)]);

  generate
    if (!FLUSH_ONE_EN) begin : g_ro_chk
      // R9
      ro_flush_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fl_one_i && !fl_all_i && !rf_we_i |=> valid_v == $past(valid_v));
    end
  endgenerate
endmodule

// File: tb/tlb_multisize_tb_top.sv
`timescale 1ns/1ps
module tlb_multisize_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        rf_we = 1'b0;
  logic [31:0] rf_va = '0, rf_pa = '0;
  logic [1:0]  rf_rgn = '0;
  logic [3:0]  rf_perm = '0;
  logic        fl_all = 1'b0, fl_one = 1'b0;
  logic [31:0] fl_va = '0;
  logic        rsp, hit, ro_rsp, ro_hit;
  logic [31:0] pa, ro_pa;
  logic [3:0]  perm, ro_perm;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tlb_multisize dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .lk_va_i(lk_va),
    .lk_rsp_o(rsp), .lk_hit_o(hit), .lk_pa_o(pa), .lk_perm_o(perm),
    .rf_we_i(rf_we), .rf_va_i(rf_va), .rf_pa_i(rf_pa), .rf_rgn_i(rf_rgn),
    .rf_perm_i(rf_perm), .fl_all_i(fl_all), .fl_one_i(fl_one), .fl_va_i(fl_va)
  );

  tlb_multisize #(.FLUSH_ONE_EN(1'b0)) dut_ro_i (
    .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .lk_va_i(lk_va),
    .lk_rsp_o(ro_rsp), .lk_hit_o(ro_hit), .lk_pa_o(ro_pa), .lk_perm_o(ro_perm),
    .rf_we_i(rf_we), .rf_va_i(rf_va), .rf_pa_i(rf_pa), .rf_rgn_i(rf_rgn),
    .rf_perm_i(rf_perm), .fl_all_i(fl_all), .fl_one_i(fl_one), .fl_va_i(fl_va)
  );

  // bench model of the main instance
  bit          mv[32];
  logic [31:0] mvt[32], mpt[32];
  int          msz[32];
  logic [3:0]  mperm[32];
  int          mptr = 0;

  function automatic logic [31:0] rbytes(input int sz);
    if (sz == 1) return 32'd65536;
    if (sz == 2) return 32'd1048576;
    return 32'd4096;
  endfunction

  function automatic bit covers(input int i, input logic [31:0] va);
    logic [31:0] b;
    b = rbytes(msz[i]);
    return mv[i] && ((va / b) == (mvt[i] / b));
  endfunction

  task automatic mlook(input logic [31:0] va, output bit h,
                       output logic [31:0] xpa, output logic [3:0] xpm);
    logic [31:0] b;
    h = 0; xpa = '0; xpm = '0;
    for (int i = 0; i < 32; i++) begin
      if (!h && covers(i, va)) begin
        b = rbytes(msz[i]);
        h = 1;
        xpa = (mpt[i] / b) * b + (va % b);
        xpm = mperm[i];
      end
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive lookup; outputs are read at the next falling edge
  task automatic lookup(input logic [31:0] va, input string req);
    bit h; logic [31:0] xpa; logic [3:0] xpm;
    mlook(va, h, xpa, xpm);
    lk_req = 1'b1; lk_va = va;
    @(negedge clk);
    lk_req = 1'b0;
    check(req, "rsp", {31'd0, rsp}, 32'd1);
    check(req, "hit", {31'd0, hit}, {31'd0, h});
    check(req, "pa", pa, xpa);
    check(req, "perm", {28'd0, perm}, {28'd0, xpm});
  endtask

  task automatic m_refill(input logic [31:0] va, input logic [31:0] p,
                          input int sz, input logic [3:0] pm);
    mv[mptr] = 1; mvt[mptr] = va; mpt[mptr] = p; msz[mptr] = sz; mperm[mptr] = pm;
    mptr = (mptr + 1) % 32;
  endtask

  task automatic refill(input logic [31:0] va, input logic [31:0] p,
                        input int sz, input logic [3:0] pm);
    rf_we = 1'b1; rf_va = va; rf_pa = p; rf_rgn = 2'(sz); rf_perm = pm;
    @(negedge clk);
    rf_we = 1'b0;
    m_refill(va, p, sz, pm);
  endtask

  task automatic m_flush_all();
    for (int i = 0; i < 32; i++) mv[i] = 0;
  endtask

  task automatic flush_all();
    fl_all = 1'b1;
    @(negedge clk);
    fl_all = 1'b0;
    m_flush_all();
  endtask

  task automatic flush_one(input logic [31:0] va);
    bit kill[32];
    for (int i = 0; i < 32; i++) kill[i] = covers(i, va);
    fl_one = 1'b1; fl_va = va;
    @(negedge clk);
    fl_one = 1'b0;
    for (int i = 0; i < 32; i++) if (kill[i]) mv[i] = 0;
  endtask

  // lookups around the region edges of a base address
  task automatic sweep(input logic [31:0] base, input string req);
    logic [31:0] offs[8] = '{32'h0, 32'hFFF, 32'h1000, 32'hFFFF,
                             32'h10000, 32'hFFFFF, 32'h100000, 32'hFFFFFFFF};
    for (int k = 0; k < 8; k++) lookup(base + offs[k], req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "rsp in reset", {31'd0, rsp}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    lookup(32'h0000_0000, "R1");
    lookup(32'hFFFF_F000, "R1");

    // R2: idle cycle gives no response
    @(negedge clk);
    check("R2", "idle rsp", {31'd0, rsp}, 32'd0);
    check("R2", "idle hit", {31'd0, hit}, 32'd0);

    // R3 R4: one slot of each region code, unaligned refill addresses
    refill(32'h1234_5678, 32'hABC1_2345, 2, 4'h5);
    refill(32'h0045_1234, 32'h7777_0000, 1, 4'h3);
    refill(32'h0009_A123, 32'h0001_2000, 0, 4'h9);
    refill(32'h8000_1000, 32'h4444_6000, 3, 4'hF);
    sweep(32'h1230_0000, "R3");
    sweep(32'h0045_0000, "R3");
    sweep(32'h0009_A000, "R4");
    sweep(32'h8000_1000, "R4");
    lookup(32'h123F_FFFF, "R4");
    lookup(32'h0045_ABCD, "R4");

    // R5: slot 4 overlaps slot 0, slot 0 must win
    refill(32'h1234_0000, 32'h5555_5000, 0, 4'h1);
    lookup(32'h1234_0010, "R5");
    check("R5", "pa low slot", pa, 32'hABC4_0010);

    // R8: one flush removes both overlapping slots
    flush_one(32'h1234_0ABC);
    lookup(32'h1234_0010, "R8");
    lookup(32'h1230_0000, "R8");
    lookup(32'h0045_0000, "R8");
    lookup(32'h0009_A000, "R8");

    // R10: lookup in the flush cycle sees the old contents
    lk_req = 1'b1; lk_va = 32'h0045_0004; fl_all = 1'b1;
    @(negedge clk);
    lk_req = 1'b0; fl_all = 1'b0;
    check("R10", "hit at flush", {31'd0, hit}, 32'd1);
    check("R10", "pa at flush", pa, 32'h7777_0004);
    m_flush_all();
    // R7
    lookup(32'h0045_0004, "R7");
    lookup(32'h8000_1000, "R7");

    // R11: refill and flush-all in the same cycle
    refill(32'h2000_0000, 32'h3000_0000, 0, 4'h2);
    rf_we = 1'b1; rf_va = 32'h2100_0000; rf_pa = 32'h3100_0000; rf_rgn = 2'd1; rf_perm = 4'h6;
    fl_all = 1'b1;
    @(negedge clk);
    rf_we = 1'b0; fl_all = 1'b0;
    m_flush_all();
    m_refill(32'h2100_0000, 32'h3100_0000, 1, 4'h6);
    lookup(32'h2100_0042, "R11");
    check("R11", "survivor hit", {31'd0, hit}, 32'd1);
    lookup(32'h2000_0000, "R11");

    // R6: fill all slots, then one more evicts the first of them
    flush_all();
    for (int i = 0; i < 32; i++)
      refill(32'h4000_0000 + (i << 12), 32'h0800_0000 + (i << 12), 0, 4'(i));
    for (int i = 0; i < 32; i++) lookup(32'h4000_0000 + (i << 12) + 32'h44, "R6");
    refill(32'h5000_0000, 32'h0900_0000, 0, 4'hA);
    lookup(32'h4000_0000, "R6");
    check("R6", "first evicted", {31'd0, hit}, 32'd0);
    lookup(32'h4000_1000, "R6");
    lookup(32'h5000_0000, "R6");

    // R9: the variant without single flush keeps the slot
    flush_all();
    refill(32'h6000_0000, 32'h6100_0000, 0, 4'h7);
    flush_one(32'h6000_0000);
    lookup(32'h6000_0008, "R8");
    check("R9", "ro rsp", {31'd0, ro_rsp}, 32'd1);
    check("R9", "ro hit", {31'd0, ro_hit}, 32'd1);
    check("R9", "ro pa", ro_pa, 32'h6100_0008);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule